// File: doc/BRIEF.md
# Idle and Power-Down Mode Controller

This block sets the low-power modes of a small microcontroller. Software writes a two-bit power-control register. The block turns the register into three gating enables: one for the CPU clock, one for the peripheral clocks (timers, serial channel, interrupt logic) and one for the oscillator. In idle, the CPU clock stops and the peripherals keep running. In power-down, the oscillator stops. Any enabled interrupt request ends idle. Power-down ends only through a hardware reset.

The block also qualifies the external reset pin. The internal reset asserts only after the pin has been high for two machine cycles. While that reset is active, the block holds a RAM-write-inhibit output high, so that the reset clears the control state but leaves RAM untouched. The qualification counter runs from the free-running reference clock, so a reset can end power-down even while the gated oscillator is off. After such a reset the oscillator is enabled again. The CPU and peripheral clocks stay off for a parameterised settling time and are then released.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: Bit 0 of the control register requests idle and bit 1 requests power-down. `ctl_bits` shows the register, and `mode` encodes RUN as 0, IDLE as 1 and PDOWN as 2. A write in RUN updates `ctl_bits` and `mode` on the same clock edge.
- R2: A write with both bits set enters PDOWN, not IDLE.
- R3: In IDLE, `cpu_clk_en` is 0 while `per_clk_en` and `osc_en` are 1. In RUN all three are 1.
- R4: In IDLE, any bit of `irq` returns the block to RUN at the next edge and clears register bit 0.
- R5: In PDOWN, all three enables are 0. Interrupt requests and register writes leave `mode` and `ctl_bits` unchanged.
- R6: `sys_rst` rises after the 24th consecutive edge (MC_CLKS*RST_MC) at which `rst_pin` is sampled high. A low sample restarts the count and drops `sys_rst` at that edge.
- R7: While `sys_rst` is high, the register is cleared, a block outside PDOWN is held in RUN, writes are ignored, and `ram_wr_inhibit` equals `sys_rst`.
- R8: When `sys_rst` is seen in PDOWN, `osc_en` rises at the next edge. The CPU and peripheral enables stay 0 for OSC_SETTLE further edges, after which the mode is RUN.
- R9: In IDLE, register writes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| rst_pin | input | 1 | External reset pin, active high, not yet qualified |
| wr_en | input | 1 | Write strobe for the control register |
| wr_data | input | 2 | Write data: bit 0 requests idle, bit 1 requests power-down |
| irq | input | NIRQ | Interrupt requests that are already enabled |
| ctl_bits | output | 2 | Current control register |
| mode | output | 2 | Registered mode code: 0 RUN, 1 IDLE, 2 PDOWN |
| cpu_clk_en | output | 1 | CPU clock enable |
| per_clk_en | output | 1 | Peripheral clock enable |
| osc_en | output | 1 | Oscillator enable |
| sys_rst | output | 1 | Qualified internal reset |
| ram_wr_inhibit | output | 1 | Blocks RAM writes during internal reset |

## Verification
The assertions assume a few things about the inputs. `clk` keeps running in power-down. `irq` carries only requests that are already enabled. Writes come from a CPU that is clocked only in RUN, so a write in another mode must have no effect. The stimulus changes inputs only on the falling edge, one step per cycle. It keeps `rst_pin` high, without interruption, through the whole wake-up from power-down, and it reaches every mode only through register writes, interrupts and reset.

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl #(
  parameter int MC_CLKS    = 12,
  parameter int RST_MC     = 2,
  parameter int OSC_SETTLE = 16,
  parameter int NIRQ       = 5
) (
  input  logic            clk,
  input  logic            por_n,
  input  logic            rst_pin,
  input  logic            wr_en,
  input  logic [1:0]      wr_data,
  input  logic [NIRQ-1:0] irq,
  output logic [1:0]      ctl_bits,
  output logic [1:0]      mode,
  output logic            cpu_clk_en,
  output logic            per_clk_en,
  output logic            osc_en,
  output logic            sys_rst,
  output logic            ram_wr_inhibit
);
  localparam int RST_CYC = MC_CLKS * RST_MC;
  localparam int CW = $clog2(RST_CYC + 1);
  localparam int SW = (OSC_SETTLE > 1) ? $clog2(OSC_SETTLE) : 1;
  localparam logic [1:0] M_RUN = 2'd0, M_IDLE = 2'd1, M_PDOWN = 2'd2;
  localparam logic [CW-1:0] RST_LAST = CW'(RST_CYC - 1);
  localparam logic [CW-1:0] RST_SAT  = CW'(RST_CYC);
  localparam logic [SW-1:0] STL_LAST = SW'(OSC_SETTLE - 1);

  logic [CW-1:0] hi_cnt;
  logic          rst_q;
  logic [SW-1:0] stl_cnt;
  logic          waking;
  logic [1:0]    pcon;
  logic [1:0]    mode_q;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      hi_cnt <= '0;
      rst_q  <= 1'b0;
    end else if (!rst_pin) begin
      hi_cnt <= '0;
      rst_q  <= 1'b0;
    end else begin
      if (hi_cnt != RST_SAT) hi_cnt <= hi_cnt + 1'b1;
      rst_q <= (hi_cnt >= RST_LAST);
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      mode_q  <= M_RUN;
      pcon    <= 2'b00;
      waking  <= 1'b0;
      stl_cnt <= '0;
    end else if (mode_q == M_PDOWN) begin
      if (waking) begin
        if (stl_cnt == STL_LAST) begin
          waking  <= 1'b0;
          stl_cnt <= '0;
          mode_q  <= M_RUN;
          pcon    <= 2'b00;
        end else begin
          stl_cnt <= stl_cnt + 1'b1;
        end
      end else if (rst_q) begin
        waking  <= 1'b1;
        stl_cnt <= '0;
      end
    end else if (rst_q) begin
      mode_q <= M_RUN;
      pcon   <= 2'b00;
    end else if (mode_q == M_IDLE) begin
      if (|irq) begin
        pcon[0] <= 1'b0;
        mode_q  <= M_RUN;
      end
    end else if (wr_en) begin
      pcon <= wr_data;
      if (wr_data[1])      mode_q <= M_PDOWN;
      else if (wr_data[0]) mode_q <= M_IDLE;
    end
  end

  assign ctl_bits       = pcon;
  assign mode           = mode_q;
  assign cpu_clk_en     = (mode_q == M_RUN);
  assign per_clk_en     = (mode_q != M_PDOWN);
  assign osc_en         = (mode_q != M_PDOWN) || waking;
  assign sys_rst        = rst_q;
  assign ram_wr_inhibit = rst_q;
endmodule

// File: rtl/pwr_mode_ctrl_chk.sv
module pwr_mode_ctrl_chk #(
  parameter int RST_CYC = 24,
  parameter int NIRQ    = 5
) (
  input logic            clk,
  input logic            por_n,
  input logic            rst_pin,
  input logic            wr_en,
  input logic [1:0]      wr_data,
  input logic [NIRQ-1:0] irq,
  input logic [1:0]      ctl_bits,
  input logic [1:0]      mode,
  input logic            cpu_clk_en,
  input logic            per_clk_en,
  input logic            osc_en,
  input logic            sys_rst
);
  logic [15:0] pin_run;
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) pin_run <= '0;
    else if (!rst_pin) pin_run <= '0;
    else if (pin_run != 16'hFFFF) pin_run <= pin_run + 1'b1;
  end

  AST_PD_WINS: assert property (@(posedge clk) disable iff (!por_n)
    (mode == 2'd0 && !sys_rst && wr_en && wr_data == 2'b11) |=> (mode == 2'd2)); // R2
  AST_IDLE_WAKE: assert property (@(posedge clk) disable iff (!por_n)
    (mode == 2'd1 && !sys_rst && |irq) |=> (mode == 2'd0 && !ctl_bits[0])); // R4
  AST_PD_STICKY: assert property (@(posedge clk) disable iff (!por_n)
    (mode == 2'd2 && !osc_en && !sys_rst) |=> (mode == 2'd2 && $stable(ctl_bits))); // R5
  AST_RST_QUAL: assert property (@(posedge clk) disable iff (!por_n)
    $rose(sys_rst) |-> (pin_run >= 16'(RST_CYC))); // R6
  AST_OSC_FIRST: assert property (@(posedge clk) disable iff (!por_n)
    $rose(osc_en) |-> (!cpu_clk_en && !per_clk_en)); // R8
  AST_IDLE_NOWR: assert property (@(posedge clk) disable iff (!por_n)
    (mode == 2'd1 && !sys_rst && !(|irq) && wr_en) |=> (mode == 2'd1 && $stable(ctl_bits))); // R9
endmodule

bind pwr_mode_ctrl pwr_mode_ctrl_chk #(.RST_CYC(MC_CLKS * RST_MC), .NIRQ(NIRQ)) u_chk (
  .clk(clk), .por_n(por_n), .rst_pin(rst_pin), .wr_en(wr_en), .wr_data(wr_data),
  .irq(irq), .ctl_bits(ctl_bits), .mode(mode), .cpu_clk_en(cpu_clk_en),
  .per_clk_en(per_clk_en), .osc_en(osc_en), .sys_rst(sys_rst)
);

// File: tb/tb_pwr_mode_ctrl.sv
module tb_pwr_mode_ctrl;
  localparam int NIRQ = 5;
  localparam int QUAL = 24;
  localparam int SETTLE = 16;

  logic clk = 1'b0;
  logic por_n = 1'b0;
  logic rst_pin = 1'b0, wr_en = 1'b0;
  logic [1:0] wr_data = 2'b00;
  logic [NIRQ-1:0] irq = '0;
  logic [1:0] ctl_bits, mode;
  logic cpu_clk_en, per_clk_en, osc_en, sys_rst, ram_wr_inhibit;

  int total = 0, bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pwr_mode_ctrl #(.MC_CLKS(12), .RST_MC(2), .OSC_SETTLE(SETTLE), .NIRQ(NIRQ)) dut (
    .clk(clk), .por_n(por_n), .rst_pin(rst_pin), .wr_en(wr_en), .wr_data(wr_data),
    .irq(irq), .ctl_bits(ctl_bits), .mode(mode), .cpu_clk_en(cpu_clk_en),
    .per_clk_en(per_clk_en), .osc_en(osc_en), .sys_rst(sys_rst),
    .ram_wr_inhibit(ram_wr_inhibit)
  );

  // {wr, data[1:0], irq, exp_mode[1:0], exp_bits[1:0], cpu, per, osc}
  localparam logic [10:0] VEC [10] = '{
    11'b0_00_0_00_00_111,  // R3 RUN
    11'b1_01_0_01_01_011,  // R1 R3 idle
    11'b1_10_0_01_01_011,  // R9 write ignored in idle
    11'b0_00_0_01_01_011,  // R3 hold
    11'b0_00_1_00_00_111,  // R4 wake
    11'b1_10_0_10_10_000,  // R1 power-down alone
    11'b0_00_1_10_10_000,  // R5 irq ignored
    11'b1_01_0_10_10_000,  // R5 write ignored
    11'b0_00_1_10_10_000,  // R5
    11'b0_00_0_10_10_000   // R5
  };

  task automatic tick(input logic w, input logic [1:0] d, input logic q, input logic p);
    @(negedge clk);
    wr_en = w; wr_data = d; irq = q ? 5'b00100 : 5'b0; rst_pin = p;
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic chk_state(input string tag, input logic [1:0] m, input logic [1:0] b,
                           input logic [2:0] en);
    chk(mode == m, {tag, " mode"}, 32'(mode), 32'(m));
    chk(ctl_bits == b, {tag, " bits"}, 32'(ctl_bits), 32'(b));
    chk({cpu_clk_en, per_clk_en, osc_en} == en, {tag, " enables"},
        32'({cpu_clk_en, per_clk_en, osc_en}), 32'(en));
  endtask

  initial begin
    #400000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #7 por_n = 1'b1;
    #1;
    chk_state("R1 reset", 2'd0, 2'b00, 3'b111);
    chk(sys_rst == 1'b0 && ram_wr_inhibit == 1'b0, "R7 reset idle", 32'(sys_rst), 0);

    // R2: both bits set selects power-down
    tick(1'b1, 2'b11, 1'b0, 1'b0);
    chk_state("R2 both", 2'd2, 2'b11, 3'b000);
    // R6 R8: reset from power-down
    for (int i = 1; i < QUAL; i++) tick(1'b0, 2'b00, 1'b0, 1'b1);
    chk(sys_rst == 1'b0, "R6 before 24", 32'(sys_rst), 0);
    tick(1'b0, 2'b00, 1'b0, 1'b1);
    chk(sys_rst == 1'b1, "R6 at 24", 32'(sys_rst), 1);
    chk(ram_wr_inhibit == 1'b1, "R7 inhibit", 32'(ram_wr_inhibit), 1);
    chk(osc_en == 1'b0, "R8 osc still off", 32'(osc_en), 0);
    tick(1'b0, 2'b00, 1'b0, 1'b1);
    chk_state("R8 osc on", 2'd2, 2'b11, 3'b001);
    for (int i = 1; i < SETTLE; i++) tick(1'b0, 2'b00, 1'b0, 1'b1);
    chk_state("R8 settling", 2'd2, 2'b11, 3'b001);
    tick(1'b0, 2'b00, 1'b0, 1'b1);
    chk_state("R8 released", 2'd0, 2'b00, 3'b111);
    tick(1'b1, 2'b01, 1'b0, 1'b1);
    chk_state("R7 write under reset", 2'd0, 2'b00, 3'b111);
    tick(1'b0, 2'b00, 1'b0, 1'b0);
    chk(sys_rst == 1'b0 && ram_wr_inhibit == 1'b0, "R6 pin low drops", 32'(sys_rst), 0);

    // vector table
    for (int k = 0; k < 10; k++) begin
      tick(VEC[k][10], VEC[k][9:8], VEC[k][7], 1'b0);
      chk_state($sformatf("R1 vec%0d", k), VEC[k][6:5], VEC[k][4:3], VEC[k][2:0]);
    end

    // leave power-down once more
    for (int i = 0; i < QUAL + 1 + SETTLE; i++) tick(1'b0, 2'b00, 1'b0, 1'b1);
    chk_state("R8 second wake", 2'd0, 2'b00, 3'b111);
    tick(1'b0, 2'b00, 1'b0, 1'b0);

    // R6: an interrupted pulse does not qualify
    for (int i = 0; i < 10; i++) tick(1'b0, 2'b00, 1'b0, 1'b1);
    tick(1'b0, 2'b00, 1'b0, 1'b0);
    for (int i = 0; i < 20; i++) tick(1'b0, 2'b00, 1'b0, 1'b1);
    chk(sys_rst == 1'b0, "R6 restart count", 32'(sys_rst), 0);
    tick(1'b0, 2'b00, 1'b0, 1'b0);

    // R7: reset ends idle
    tick(1'b1, 2'b01, 1'b0, 1'b0);
    chk_state("R3 idle again", 2'd1, 2'b01, 3'b011);
    for (int i = 0; i < QUAL; i++) tick(1'b0, 2'b00, 1'b0, 1'b1);
    chk_state("R7 idle kept until seen", 2'd1, 2'b01, 3'b011);
    tick(1'b0, 2'b00, 1'b0, 1'b1);
    chk_state("R7 idle reset", 2'd0, 2'b00, 3'b111);
    chk(ram_wr_inhibit == sys_rst, "R7 inhibit follows", 32'(ram_wr_inhibit), 32'(sys_rst));
    tick(1'b0, 2'b00, 1'b0, 1'b0);
    chk(ram_wr_inhibit == 1'b0, "R7 inhibit off", 32'(ram_wr_inhibit), 0);

    // R4: idle bit cleared, power-down bit kept off; write after reset works
    tick(1'b1, 2'b01, 1'b0, 1'b0);
    tick(1'b0, 2'b00, 1'b1, 1'b0);
    chk_state("R4 wake2", 2'd0, 2'b00, 3'b111);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule